// File: doc/BRIEF.md
# Fuse Word Program-and-Verify Sequencer

This block writes one 32-bit logical word into a one-time-programmable fuse array through the array's command port. Every logical word is stored twice, in two neighbouring physical rows, for redundancy. For each row the sequencer reads the current contents and works out which requested one-bits are still unburnt. It burns those bits one at a time and then checks the row with a margin read. A request finishes with a refresh of the controller's shadow copy and a single-cycle done pulse.

The caller gives a start pulse, a byte address and the value to write. The sequencer drives a command strobe with an operation code and a physical address. It waits for the controller's busy flag to drop before each command and after each one, and it takes read data when busy falls after a read. The request fails only when both rows fail verification, so one weak row is tolerated. A misaligned or out-of-range address is rejected at once, and no command reaches the array.

Top module: `fuse_word_writer`

## Requirements
- R1: A start with a byte address whose two low bits are not both zero, or whose value is 0x100 or more, is rejected. In the cycle after start, done_o, fail_o and addr_err_o are 1 and err_cnt_o is 0. No command is ever strobed for it.
- R2: The logical word w = byte address / 4 is written to physical row 2w (row 0) first. Only then is any command issued for physical row 2w+1 (row 1).
- R3: Operation codes on cmd_op_o are 3'd1 power-up, 3'd2 array read, 3'd3 margin read, 3'd4 program bit and 3'd5 refresh. Power-up and refresh carry address 0. Each row starts with a power-up followed by an array read, whose address is the physical row index 2w+row in cmd_addr_o[6:0] with the upper bits zero.
- R4: For each row, exactly the bits in (value AND NOT array-read data) get a program command each, in ascending bit order. The address of a program command is {bit[4:0] in [11:7], w in [6:1], row in [0]}.
- R5: A command is strobed only when busy_i is low. The controller raises busy_i in the cycle after a strobe and holds it until the operation is finished.
- R6: After the program phase of a row, the sequencer issues a power-up and then a margin read of the same row. When no bit needs burning, the power-up and margin read follow the array read directly.
- R7: A row fails when (value AND margin-read data) differs from value. err_cnt_o ends up as the number of failed rows, 0 to 2.
- R8: fail_o is set on a valid request only when both rows failed, that is when err_cnt_o is 2.
- R9: After both rows, a power-up and then a refresh are issued. When busy_i has cleared after the refresh, done_o goes high for exactly one cycle.
- R10: A start while a sequence is running has no effect. fail_o, err_cnt_o and addr_err_o keep their values from the done pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled while idle |
| byte_addr_i | input | 12 | Byte address of the logical word |
| value_i | input | 32 | Word to write |
| busy_i | input | 1 | Fuse controller busy |
| rdata_i | input | 32 | Fuse controller read data |
| cmd_valid_o | output | 1 | Single-cycle command strobe |
| cmd_op_o | output | 3 | Command operation code |
| cmd_addr_o | output | 12 | Command physical address |
| done_o | output | 1 | Single-cycle completion pulse |
| fail_o | output | 1 | Request failed |
| err_cnt_o | output | 2 | Number of rows that failed verification |
| addr_err_o | output | 1 | Request rejected for its address |

## Verification
The assertions assume the controller raises busy_i in the cycle after every strobe and holds it until the operation is over. They also assume busy_i never rises without a strobe. The bench's controller model does exactly that, with a busy time drawn at random between one and three cycles. It also applies program commands to a model array in which chosen bits can be held stuck, so verification failures occur only where the bench puts them. Start pulses that arrive during a run are part of the stimulus, and they are also covered by the rule that no command may appear unless an accepted request is running.

// File: rtl/fuse_seq_pkg.sv
// Shared types for the fuse word sequencer.
// Assumes a 3-bit command operation field at the controller.
package fuse_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_PWRUP   = 3'd1,
        OP_AREAD   = 3'd2,
        OP_MREAD   = 3'd3,
        OP_PROG    = 3'd4,
        OP_REFRESH = 3'd5
    } fuse_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PWR_A,
        S_RD_A,
        S_SCAN,
        S_PWR_M,
        S_RD_M,
        S_CHECK,
        S_PWR_F,
        S_REFRESH,
        S_GAP,
        S_WAIT,
        S_FIN
    } seq_state_e;

endpackage

// File: rtl/fuse_req_check.sv
// Request address check. It accepts a byte address only when it is word
// aligned and lies inside the fuse area, and it returns the logical word
// index. Assumes ADDR_W >= WORD_W + 2.
module fuse_req_check #(
    parameter int ADDR_W     = 12,
    parameter int AREA_BYTES = 256,
    localparam int WORD_W    = $clog2(AREA_BYTES / 4)
)(
    input  logic [ADDR_W-1:0] byte_addr_i,
    output logic              ok_o,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(AREA_BYTES);

    // Alignment and range test
    always_comb begin
        ok_o = (byte_addr_i[1:0] == 2'b00) && ({1'b0, byte_addr_i} < LIMIT);
    end

    assign word_o = byte_addr_i[WORD_W+1:2];
endmodule

// File: rtl/fuse_low_bit.sv
// Lowest-set-bit picker. It gives the index of the lowest one in the mask,
// a flag for any one, and the mask with that bit cleared. This makes
// repeated use walk the bits in ascending order.
module fuse_low_bit #(
    parameter int W      = 32,
    localparam int IDX_W = $clog2(W)
)(
    input  logic [W-1:0]     mask_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [W-1:0]     rest_o
);
    logic [W:0]   seen;
    logic [W-1:0] first;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < W; g++) begin : g_chain
        assign first[g]  = mask_i[g] & ~seen[g];
        assign seen[g+1] = seen[g] | mask_i[g];
    end

    // Encode the one-hot first bit into an index
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign any_o  = seen[W];
    assign rest_o = mask_i & ~first;
endmodule

// File: rtl/fuse_row_verify.sv
// Row verification. A row passes when every requested one-bit reads back
// as one; extra ones in the row are allowed.
module fuse_row_verify #(
    parameter int W = 32
)(
    input  logic [W-1:0] value_i,
    input  logic [W-1:0] readback_i,
    output logic         pass_o
);
    // Covered-bits comparison
    always_comb begin
        pass_o = ((value_i & readback_i) == value_i);
    end
endmodule

// File: rtl/fuse_word_writer.sv
// Fuse word program-and-verify sequencer (top).
// For each of the two redundant rows of a logical word it does: power-up,
// array read, one program command per missing one-bit (ascending), then
// power-up and margin read, and checks the row. At the end it issues a
// power-up and a refresh and pulses done.
// Assumes the controller raises busy in the cycle after each strobe and
// holds it until the operation (and any read data) is complete.
module fuse_word_writer
    import fuse_seq_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12,
    parameter int AREA_BYTES = 256,
    localparam int WORD_W    = $clog2(AREA_BYTES / 4),
    localparam int BIT_W     = $clog2(DATA_W),
    localparam int PHY_W     = BIT_W + WORD_W + 1,
    localparam int ERR_W     = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] byte_addr_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_op_o,
    output logic [PHY_W-1:0]  cmd_addr_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [ERR_W-1:0]  err_cnt_o,
    output logic              addr_err_o
);
    localparam logic [ERR_W-1:0] ROWS = ERR_W'(2);

    seq_state_e        state_q, ret_q;
    logic [WORD_W-1:0] word_q;
    logic [DATA_W-1:0] val_q, mask_q, rb_q;
    logic              row_q;
    logic [ERR_W-1:0]  err_q;
    logic              fail_q, aerr_q, done_q;
    logic              cmd_v_q;
    fuse_op_e          cmd_op_q;
    logic [PHY_W-1:0]  cmd_addr_q;

    logic              req_ok;
    logic [WORD_W-1:0] req_word;
    logic              bit_any;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] mask_rest;
    logic              row_pass;
    logic [PHY_W-1:0]  row_addr;

    fuse_req_check #(
        .ADDR_W     (ADDR_W),
        .AREA_BYTES (AREA_BYTES)
    ) u_req (
        .byte_addr_i (byte_addr_i),
        .ok_o        (req_ok),
        .word_o      (req_word)
    );

    fuse_low_bit #(.W(DATA_W)) u_pick (
        .mask_i (mask_q),
        .any_o  (bit_any),
        .idx_o  (bit_idx),
        .rest_o (mask_rest)
    );

    fuse_row_verify #(.W(DATA_W)) u_ver (
        .value_i    (val_q),
        .readback_i (rb_q),
        .pass_o     (row_pass)
    );

    // Physical row index used by read commands
    assign row_addr = PHY_W'({word_q, row_q});

    // Sequencer state machine and command register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            ret_q      <= S_IDLE;
            word_q     <= '0;
            val_q      <= '0;
            mask_q     <= '0;
            rb_q       <= '0;
            row_q      <= 1'b0;
            err_q      <= '0;
            fail_q     <= 1'b0;
            aerr_q     <= 1'b0;
            done_q     <= 1'b0;
            cmd_v_q    <= 1'b0;
            cmd_op_q   <= OP_NONE;
            cmd_addr_q <= '0;
        end else begin
            done_q  <= 1'b0;
            cmd_v_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        if (!req_ok) begin
                            done_q <= 1'b1;
                            fail_q <= 1'b1;
                            aerr_q <= 1'b1;
                            err_q  <= '0;
                        end else begin
                            word_q  <= req_word;
                            val_q   <= value_i;
                            row_q   <= 1'b0;
                            err_q   <= '0;
                            fail_q  <= 1'b0;
                            aerr_q  <= 1'b0;
                            state_q <= S_PWR_A;
                        end
                    end
                end
                S_PWR_A: begin
                    if (!busy_i) begin
                        cmd_v_q    <= 1'b1;
                        cmd_op_q   <= OP_PWRUP;
                        cmd_addr_q <= '0;
                        ret_q      <= S_RD_A;
                        state_q    <= S_GAP;
                    end
                end
                S_RD_A: begin
                    if (!busy_i) begin
                        cmd_v_q    <= 1'b1;
                        cmd_op_q   <= OP_AREAD;
                        cmd_addr_q <= row_addr;
                        ret_q      <= S_SCAN;
                        state_q    <= S_GAP;
                    end
                end
                S_SCAN: begin
                    if (!busy_i) begin
                        if (bit_any) begin
                            cmd_v_q    <= 1'b1;
                            cmd_op_q   <= OP_PROG;
                            cmd_addr_q <= {bit_idx, word_q, row_q};
                            mask_q     <= mask_rest;
                            ret_q      <= S_SCAN;
                            state_q    <= S_GAP;
                        end else begin
                            state_q <= S_PWR_M;
                        end
                    end
                end
                S_PWR_M: begin
                    if (!busy_i) begin
                        cmd_v_q    <= 1'b1;
                        cmd_op_q   <= OP_PWRUP;
                        cmd_addr_q <= '0;
                        ret_q      <= S_RD_M;
                        state_q    <= S_GAP;
                    end
                end
                S_RD_M: begin
                    if (!busy_i) begin
                        cmd_v_q    <= 1'b1;
                        cmd_op_q   <= OP_MREAD;
                        cmd_addr_q <= row_addr;
                        ret_q      <= S_CHECK;
                        state_q    <= S_GAP;
                    end
                end
                S_CHECK: begin
                    if (!row_pass) err_q <= err_q + ERR_W'(1);
                    if (!row_q) begin
                        row_q   <= 1'b1;
                        state_q <= S_PWR_A;
                    end else begin
                        state_q <= S_PWR_F;
                    end
                end
                S_PWR_F: begin
                    if (!busy_i) begin
                        cmd_v_q    <= 1'b1;
                        cmd_op_q   <= OP_PWRUP;
                        cmd_addr_q <= '0;
                        ret_q      <= S_REFRESH;
                        state_q    <= S_GAP;
                    end
                end
                S_REFRESH: begin
                    if (!busy_i) begin
                        cmd_v_q    <= 1'b1;
                        cmd_op_q   <= OP_REFRESH;
                        cmd_addr_q <= '0;
                        ret_q      <= S_FIN;
                        state_q    <= S_GAP;
                    end
                end
                S_GAP: begin
                    state_q <= S_WAIT;
                end
                S_WAIT: begin
                    if (!busy_i) begin
                        if (cmd_op_q == OP_AREAD) mask_q <= val_q & ~rdata_i;
                        if (cmd_op_q == OP_MREAD) rb_q <= rdata_i;
                        state_q <= ret_q;
                    end
                end
                S_FIN: begin
                    done_q  <= 1'b1;
                    fail_q  <= (err_q == ROWS);
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign cmd_valid_o = cmd_v_q;
    assign cmd_op_o    = cmd_op_q;
    assign cmd_addr_o  = cmd_addr_q;
    assign done_o      = done_q;
    assign fail_o      = fail_q;
    assign err_cnt_o   = err_q;
    assign addr_err_o  = aerr_q;
endmodule

// File: rtl/fuse_word_writer_chk.sv
// Protocol checker for fuse_word_writer, attached by bind. It keeps its own
// record of whether a request is running and of the last command issued.
// Assumes the controller raises busy in the cycle after each strobe.
module fuse_word_writer_chk #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12,
    parameter int AREA_BYTES = 256,
    localparam int WORD_W    = $clog2(AREA_BYTES / 4),
    localparam int BIT_W     = $clog2(DATA_W),
    localparam int PHY_W     = BIT_W + WORD_W + 1
)(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] byte_addr_i,
    input logic              busy_i,
    input logic              cmd_valid_o,
    input logic [2:0]        cmd_op_o,
    input logic [PHY_W-1:0]  cmd_addr_o,
    input logic              done_o,
    input logic              fail_o,
    input logic [1:0]        err_cnt_o,
    input logic              addr_err_o
);
    logic             bad_req;
    logic             active_q;
    logic [2:0]       last_op_q;
    logic             prog_seen_q;
    logic [BIT_W-1:0] last_bit_q;
    logic [BIT_W-1:0] cmd_bit;

    assign bad_req = (byte_addr_i[1:0] != 2'b00) ||
                     ({1'b0, byte_addr_i} >= (ADDR_W + 1)'(AREA_BYTES));
    assign cmd_bit = cmd_addr_o[PHY_W-1:PHY_W-BIT_W];

    // Track the running request and the command history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q    <= 1'b0;
            last_op_q   <= 3'd0;
            prog_seen_q <= 1'b0;
            last_bit_q  <= '0;
        end else begin
            if (start_i && !active_q && !bad_req) active_q <= 1'b1;
            else if (done_o) active_q <= 1'b0;
            if (cmd_valid_o) begin
                last_op_q <= cmd_op_o;
                if (cmd_op_o == 3'd2) prog_seen_q <= 1'b0;
                if (cmd_op_o == 3'd4) begin
                    prog_seen_q <= 1'b1;
                    last_bit_q  <= cmd_bit;
                end
            end
        end
    end

    assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !active_q && bad_req |=>
            done_o && fail_o && addr_err_o && (err_cnt_o == 2'd0));

    assert_no_stray_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> active_q);

    assert_read_powered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && (cmd_op_o == 3'd2 || cmd_op_o == 3'd3) |-> last_op_q == 3'd1);

    assert_prog_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && (cmd_op_o == 3'd4) && prog_seen_q |-> cmd_bit > last_bit_q);

    assert_idle_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !busy_i);

    assert_fail_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !addr_err_o |-> fail_o == (err_cnt_o == 2'd2));

    assert_refresh_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !addr_err_o |-> last_op_q == 3'd5);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_i) && !done_o |-> $stable(fail_o) && $stable(addr_err_o));
endmodule

bind fuse_word_writer fuse_word_writer_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .AREA_BYTES (AREA_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .byte_addr_i (byte_addr_i),
    .busy_i      (busy_i),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (cmd_op_o),
    .cmd_addr_o  (cmd_addr_o),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .err_cnt_o   (err_cnt_o),
    .addr_err_o  (addr_err_o)
);

// File: tb/tb_fuse_word_writer.sv
`timescale 1ns/1ps
// Bench for fuse_word_writer: a behavioural fuse controller with random
// busy time and stuck bits, directed corner cases and seeded random writes.
module tb_fuse_word_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [11:0] byte_addr_i = '0;
    logic [31:0] value_i = '0;
    logic        busy_i;
    logic [31:0] rdata_i;
    logic        cmd_valid_o;
    logic [2:0]  cmd_op_o;
    logic [11:0] cmd_addr_o;
    logic        done_o, fail_o, addr_err_o;
    logic [1:0]  err_cnt_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fuse_word_writer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_addr_i(byte_addr_i),
        .value_i(value_i), .busy_i(busy_i), .rdata_i(rdata_i),
        .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o),
        .done_o(done_o), .fail_o(fail_o), .err_cnt_o(err_cnt_o), .addr_err_o(addr_err_o)
    );

    // Controller model state and command log
    logic [31:0] fuse_mem [128];
    logic [31:0] stuck [128];
    int          busy_cnt = 0;
    int          proto_err = 0;
    logic [2:0]  log_op [256];
    logic [11:0] log_addr [256];
    int          log_n = 0;
    logic [2:0]  exp_op [256];
    logic [11:0] exp_addr [256];
    int          exp_n = 0;

    assign busy_i = (busy_cnt != 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0;
            rdata_i  <= '0;
        end else begin
            if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            if (cmd_valid_o) begin
                if (busy_i) proto_err = proto_err + 1;
                if (log_n < 256) begin
                    log_op[log_n]   = cmd_op_o;
                    log_addr[log_n] = cmd_addr_o;
                end
                log_n = log_n + 1;
                busy_cnt <= 1 + int'($urandom_range(0, 2));
                if (cmd_op_o == 3'd2 || cmd_op_o == 3'd3)
                    rdata_i <= fuse_mem[cmd_addr_o[6:0]];
                if (cmd_op_o == 3'd4 && !stuck[cmd_addr_o[6:0]][cmd_addr_o[11:7]])
                    fuse_mem[cmd_addr_o[6:0]][cmd_addr_o[11:7]] <= 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] op, input logic [11:0] a);
        exp_op[exp_n]   = op;
        exp_addr[exp_n] = a;
        exp_n++;
    endtask

    // Expected command sequence from the requirements
    task automatic build_exp(input int w, input logic [31:0] val,
                             input logic [31:0] o0, input logic [31:0] o1);
        exp_n = 0;
        for (int r = 0; r < 2; r++) begin
            logic [31:0] burn;
            burn = val & ~((r == 0) ? o0 : o1);
            push(3'd1, 12'd0);
            push(3'd2, 12'((w << 1) | r));
            for (int b = 0; b < 32; b++)
                if (burn[b]) push(3'd4, 12'((b << 7) | (w << 1) | r));
            push(3'd1, 12'd0);
            push(3'd3, 12'((w << 1) | r));
        end
        push(3'd1, 12'd0);
        push(3'd5, 12'd0);
    endtask

    // One valid write with full checking; optional start during the run
    task automatic do_write(input int w, input logic [31:0] val, input bit mid);
        logic [31:0] o0, o1, n0, n1;
        int          ecnt, n, mism;
        o0 = fuse_mem[2*w];
        o1 = fuse_mem[2*w+1];
        n0 = o0 | (val & ~stuck[2*w]);
        n1 = o1 | (val & ~stuck[2*w+1]);
        ecnt = (((val & n0) != val) ? 1 : 0) + (((val & n1) != val) ? 1 : 0);
        build_exp(w, val, o0, o1);
        @(negedge clk);
        log_n = 0;
        proto_err = 0;
        start_i = 1'b1;
        byte_addr_i = 12'(w * 4);
        value_i = val;
        @(negedge clk);
        start_i = 1'b0;
        if (mid) begin
            repeat (4) @(negedge clk);
            start_i = 1'b1;
            byte_addr_i = 12'h040;
            value_i = ~val;
            @(negedge clk);
            start_i = 1'b0;
            value_i = '0;
        end
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o, "R9", "done seen", 64'(done_o), 64'd1);
        chk(err_cnt_o == 2'(ecnt), "R7", "failed row count", 64'(err_cnt_o), 64'(ecnt));
        chk(fail_o == (ecnt == 2), "R8", "fail flag", 64'(fail_o), 64'(ecnt == 2));
        chk(!addr_err_o, "R1", "no addr error on valid", 64'(addr_err_o), 64'd0);
        chk(log_n == exp_n, mid ? "R10" : "R2", "command count", 64'(log_n), 64'(exp_n));
        mism = 0;
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (log_op[i] != exp_op[i] || log_addr[i] != exp_addr[i]) mism++;
        chk(mism == 0, "R4", "command sequence mismatches", 64'(mism), 64'd0);
        chk(fuse_mem[2*w] == n0 && fuse_mem[2*w+1] == n1, "R4", "burnt rows",
            {fuse_mem[2*w], fuse_mem[2*w+1]}, {n0, n1});
        chk(proto_err == 0, "R5", "strobes while busy", 64'(proto_err), 64'd0);
        @(negedge clk);
        chk(!done_o, "R9", "done one cycle", 64'(done_o), 64'd0);
        repeat (3) @(negedge clk);
        chk(err_cnt_o == 2'(ecnt) && fail_o == (ecnt == 2), "R10", "result held",
            64'({fail_o, err_cnt_o}), 64'({(ecnt == 2), 2'(ecnt)}));
    endtask

    task automatic do_reject(input logic [11:0] a);
        @(negedge clk);
        log_n = 0;
        start_i = 1'b1;
        byte_addr_i = a;
        value_i = 32'hFFFF_FFFF;
        @(negedge clk);
        chk(done_o && fail_o && addr_err_o && err_cnt_o == 2'd0, "R1", "reject flags",
            64'({done_o, fail_o, addr_err_o, err_cnt_o}), 64'b11100);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(log_n == 0, "R1", "commands on reject", 64'(log_n), 64'd0);
        chk(fail_o && addr_err_o, "R10", "reject result held",
            64'({fail_o, addr_err_o}), 64'b11);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        for (int i = 0; i < 128; i++) begin
            fuse_mem[i] = $urandom;
            stuck[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !cmd_valid_o && !fail_o && err_cnt_o == 0 && !addr_err_o, "R9",
            "reset outputs", 64'({done_o, cmd_valid_o, fail_o, err_cnt_o, addr_err_o}), 64'd0);

        // Blank word, every bit burnt in both rows
        fuse_mem[0] = '0; fuse_mem[1] = '0;
        do_write(0, 32'hFFFF_FFFF, 1'b0);
        // Zero value: no program phase (R6)
        do_write(5, 32'h0, 1'b0);
        // Already burnt: no program phase (R6)
        fuse_mem[20] = 32'hA5A5_0F0F; fuse_mem[21] = 32'hA5A5_0F0F;
        do_write(10, 32'h8421_0101, 1'b0);
        // Last valid word, sparse bits
        fuse_mem[126] = '0; fuse_mem[127] = 32'h1;
        do_write(63, 32'h8000_0001, 1'b0);
        // One weak row: tolerated (R7)
        fuse_mem[14] = '0; fuse_mem[15] = '0; stuck[14] = 32'h0000_0100;
        do_write(7, 32'h0000_FF00, 1'b0);
        // Both rows weak: fail (R8)
        fuse_mem[16] = '0; fuse_mem[17] = '0;
        stuck[16] = 32'h4000_0000; stuck[17] = 32'h0000_0002;
        do_write(8, 32'h4000_0003, 1'b0);
        stuck[14] = '0; stuck[16] = '0; stuck[17] = '0;
        // Start during a run is ignored (R10)
        fuse_mem[6] = '0; fuse_mem[7] = '0;
        do_write(3, 32'h00F0_00F0, 1'b1);
        // Rejected addresses (R1)
        do_reject(12'h101);
        do_reject(12'h100);
        do_reject(12'hFFC);
        do_reject(12'h002);
        // Seeded random writes
        for (int t = 0; t < 24; t++) begin
            int w;
            logic [31:0] v;
            w = int'($urandom_range(0, 63));
            v = $urandom;
            if (t % 4 == 0) v = fuse_mem[2*w] & $urandom;
            do_write(w, v, 1'b0);
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule